// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block lets two processors, one on each side of a shared-memory system, pass short messages to each other. There are two mailbox words, one owned by each port. Each port also has one interrupt line. When port A writes into the mailbox that port B owns, the message word is stored as written and B's interrupt line goes active. B takes the message by reading its own mailbox, and that read also clears its interrupt. Either port can read the other port's mailbox at any time. Such a read returns the stored word and does not touch the interrupt.

Each port drives a select strobe, a write flag, a one-bit mailbox address and a write data word. It also receives a busy input from the contention arbiter that sits next to the block. While a port's busy input is active, that port's accesses cannot change any message or interrupt state. Read data is registered. The interrupt outputs come straight from flip-flops and are active low.

Top module: `mbx_top`

## Requirements
- R1: After reset, both interrupt outputs are high (inactive), both read data outputs are zero, and both mailboxes hold zero.
- R2: A port write takes effect when select=1, write=1 and busy=0. The mailbox address encodes 0 = mailbox owned by port A and 1 = mailbox owned by port B. Such a write to the opposite port's mailbox stores the write data in that mailbox.
- R3: An accepted write to the opposite port's mailbox drives the owner's interrupt output low at the clock edge that completes the write.
- R4: A read by the owner of its own mailbox (select=1, write=0, busy=0) drives the owner's interrupt output high at that clock edge.
- R5: A read of the opposite port's mailbox returns its contents and leaves both interrupt outputs unchanged.
- R6: A write issued while that port's busy input is 1 changes neither the mailbox contents nor any interrupt output.
- R7: An owner read issued while the owner's busy input is 1 still returns the mailbox contents, but it leaves the owner's interrupt unchanged.
- R8: When a set and a clear reach the same interrupt in the same cycle, the set wins and the interrupt stays low. The owner's read in that cycle returns the word stored before the edge.
- R9: A port's write to its own mailbox is ignored. The contents and interrupts stay unchanged.
- R10: A read presents the mailbox word on that port's read data output one clock after the read strobe. The output holds that value until the port's next read.
- R11: The message word is stored and returned unmodified across its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aSel | input | 1 | Port A access strobe |
| aWr | input | 1 | Port A write (1) or read (0) |
| aBox | input | 1 | Port A mailbox address (0 = A's box, 1 = B's box) |
| aBusy | input | 1 | Port A busy from arbiter |
| aWdata | input | DATA_W | Port A write data |
| aRdata | output | DATA_W | Port A registered read data |
| aIntN | output | 1 | Port A interrupt, active low |
| bSel | input | 1 | Port B access strobe |
| bWr | input | 1 | Port B write (1) or read (0) |
| bBox | input | 1 | Port B mailbox address (0 = A's box, 1 = B's box) |
| bBusy | input | 1 | Port B busy from arbiter |
| bWdata | input | DATA_W | Port B write data |
| bRdata | output | DATA_W | Port B registered read data |
| bIntN | output | 1 | Port B interrupt, active low |

## Verification
The main function is exercised with directed sequences and with random traffic. The directed part runs a cross-write followed by an owner read, which separates setting from clearing. It repeats the same accesses with busy held active, which shows that the gating applies to setting and to clearing independently. It includes a non-owner read, which shows that reading has no side effect when the reader is not the owner. It includes a same-cycle write and owner read, which shows that the set has priority and that the read returns the word from before the edge. Self-writes and words with extreme bit patterns cover the ignore rule and full-width storage. Random mixes of strobes, busy and addresses are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_PORTS = 2;

  // Strobes from the control path to the datapath, one bit per port/box.
  typedef struct packed {
    logic [NUM_PORTS-1:0] load;   // box b takes the opposite port's data
    logic [NUM_PORTS-1:0] rdEn;   // port p captures a read
    logic [NUM_PORTS-1:0] rdBox;  // which box port p reads
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] sel,
  input  logic [NUM_PORTS-1:0] wr,
  input  logic [NUM_PORTS-1:0] box,
  input  logic [NUM_PORTS-1:0] busy,
  output mbxStrobes_t          strb,
  output logic [NUM_PORTS-1:0] intN
);
  logic [NUM_PORTS-1:0] wrOk;
  logic [NUM_PORTS-1:0] rdReq;
  logic [NUM_PORTS-1:0] ownClr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic SELF = 1'(p);
    localparam int   PEER = NUM_PORTS - 1 - p;

    // Accepted write: not blocked by arbiter, aimed at the peer's box.
    assign wrOk[p]   = sel[p] & wr[p] & ~busy[p] & (box[p] != SELF);
    assign rdReq[p]  = sel[p] & ~wr[p];
    // Owner read that is allowed to clear its own interrupt.
    assign ownClr[p] = rdReq[p] & ~busy[p] & (box[p] == SELF);

    assign strb.rdEn[p]  = rdReq[p];
    assign strb.rdBox[p] = box[p];
    // Box p is only ever loaded by its peer.
    assign strb.load[p]  = wrOk[PEER];

    // Interrupt flop: set has priority over clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              intN[p] <= 1'b1;
      else if (wrOk[PEER])     intN[p] <= 1'b0;
      else if (ownClr[p])      intN[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  mbxStrobes_t                       strb,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata
);
  logic [NUM_PORTS-1:0][DATA_W-1:0] msgBox;

  for (genvar b = 0; b < NUM_PORTS; b++) begin : g_box
    localparam int PEER = NUM_PORTS - 1 - b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            msgBox[b] <= '0;
      else if (strb.load[b]) msgBox[b] <= wdata[PEER];
    end

    // Port b read register: captures the box value before this edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rdata[b] <= '0;
      else if (strb.rdEn[b]) rdata[b] <= msgBox[strb.rdBox[b]];
    end
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aSel,
  input  logic              aWr,
  input  logic              aBox,
  input  logic              aBusy,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aIntN,
  input  logic              bSel,
  input  logic              bWr,
  input  logic              bBox,
  input  logic              bBusy,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bIntN
);
  mbxStrobes_t                      strb;
  logic [NUM_PORTS-1:0]             intVec;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdVec;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdVec;

  assign wdVec  = {bWdata, aWdata};
  assign aRdata = rdVec[0];
  assign bRdata = rdVec[1];
  assign aIntN  = intVec[0];
  assign bIntN  = intVec[1];

  mbx_ctrl u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  ({bSel, aSel}),
    .wr   ({bWr, aWr}),
    .box  ({bBox, aBox}),
    .busy ({bBusy, aBusy}),
    .strb (strb),
    .intN (intVec)
  );

  mbx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk  (clk),
    .rst_n(rst_n),
    .strb (strb),
    .wdata(wdVec),
    .rdata(rdVec)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aSel,
  input logic              aWr,
  input logic              aBox,
  input logic              aBusy,
  input logic [DATA_W-1:0] aWdata,
  input logic [DATA_W-1:0] aRdata,
  input logic              aIntN,
  input logic              bSel,
  input logic              bWr,
  input logic              bBox,
  input logic              bBusy,
  input logic [DATA_W-1:0] bWdata,
  input logic [DATA_W-1:0] bRdata,
  input logic              bIntN
);
  logic aSetsB, bSetsA, aOwnRd, bOwnRd;
  assign aSetsB = aSel && aWr && !aBusy && aBox;
  assign bSetsA = bSel && bWr && !bBusy && !bBox;
  assign aOwnRd = aSel && !aWr && !aBusy && !aBox;
  assign bOwnRd = bSel && !bWr && !bBusy && bBox;

  assert_set_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aSetsB |=> !bIntN);
  assert_set_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bSetsA |=> !aIntN);
  assert_clr_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (aOwnRd && !bSetsA) |=> aIntN);
  assert_clr_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bOwnRd && !aSetsB) |=> bIntN);
  assert_fall_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aIntN) |-> $past(bSetsA));
  assert_fall_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bIntN) |-> $past(aSetsB));
  assert_rise_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aIntN) |-> $past(aOwnRd));
  assert_rise_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bIntN) |-> $past(bOwnRd));
  assert_hold_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(aSel && !aWr) |=> $stable(aRdata));
  assert_hold_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bSel && !bWr) |=> $stable(bRdata));
endmodule

bind mbx_top mbx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbx_top_test.sv
module mbx_top_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aSel = 0, aWr = 0, aBox = 0, aBusy = 0;
  logic bSel = 0, bWr = 0, bBox = 0, bBusy = 0;
  logic [W-1:0] aWdata = '0, bWdata = '0;
  logic [W-1:0] aRdata, bRdata;
  logic aIntN, bIntN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model: mailbox, pending flag (1 = active), read register.
  logic [W-1:0] mBox [2];
  logic         mInt [2];
  logic [W-1:0] mRd  [2];

  always #10 clk = ~clk;  // 50 MHz

  mbx_top #(.DATA_W(W)) uut (.*);

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, "aIntN", W'(aIntN), W'(!mInt[0]));
    check(tag, "bIntN", W'(bIntN), W'(!mInt[1]));
    check(tag, "aRdata", aRdata, mRd[0]);
    check(tag, "bRdata", bRdata, mRd[1]);
  endtask

  // Model of one clock edge, computed from the requirements.
  function automatic void modelStep();
    logic         s [2], w [2], x [2], y [2];
    logic [W-1:0] d [2];
    logic [W-1:0] oldBox [2];
    logic         setF [2], clrF [2];
    s = '{aSel, bSel}; w = '{aWr, bWr}; x = '{aBox, bBox}; y = '{aBusy, bBusy};
    d = '{aWdata, bWdata};
    oldBox = mBox;
    setF = '{1'b0, 1'b0}; clrF = '{1'b0, 1'b0};
    for (int p = 0; p < 2; p++) begin
      if (s[p] && w[p] && !y[p] && (int'(x[p]) != p)) begin
        mBox[x[p]] = d[p];
        setF[x[p]] = 1'b1;
      end
      if (s[p] && !w[p]) begin
        mRd[p] = oldBox[x[p]];
        if (int'(x[p]) == p && !y[p]) clrF[p] = 1'b1;
      end
    end
    for (int p = 0; p < 2; p++)
      if (setF[p]) mInt[p] = 1'b1;
      else if (clrF[p]) mInt[p] = 1'b0;
  endfunction

  task automatic cyc(logic as, logic aw, logic ab, logic ay, logic [W-1:0] ad,
                     logic bs, logic bw, logic bb, logic by, logic [W-1:0] bd);
    aSel = as; aWr = aw; aBox = ab; aBusy = ay; aWdata = ad;
    bSel = bs; bWr = bw; bBox = bb; bBusy = by; bWdata = bd;
    @(posedge clk);
    if (rst_n) modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0,0,0,0,'0, 0,0,0,0,'0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    for (int i = 0; i < 2; i++) begin mBox[i] = '0; mInt[i] = 0; mRd[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1,0,0,0,'0, 1,0,0,0,'0);   // both read box A
    checkAll("R1");
    check("R1", "aRdata", aRdata, '0);

    // R2 R3: A writes into B's mailbox
    cyc(1,1,1,0,16'hA5C3, 0,0,0,0,'0);
    check("R3", "bIntN", W'(bIntN), W'(0));
    check("R3", "aIntN", W'(aIntN), W'(1));
    // R5: A reads B's box, no side effect
    cyc(1,0,1,0,'0, 0,0,0,0,'0);
    check("R5", "aRdata", aRdata, 16'hA5C3);
    check("R5", "bIntN", W'(bIntN), W'(0));
    // R7: B owner read while busy
    cyc(0,0,0,0,'0, 1,0,1,1,'0);
    check("R7", "bRdata", bRdata, 16'hA5C3);
    check("R7", "bIntN", W'(bIntN), W'(0));
    // R2 R4: owner read clears
    cyc(0,0,0,0,'0, 1,0,1,0,'0);
    check("R2", "bRdata", bRdata, 16'hA5C3);
    check("R4", "bIntN", W'(bIntN), W'(1));
    // R10: read data holds while idle
    idle(); idle();
    check("R10", "bRdata", bRdata, 16'hA5C3);
    checkAll("R10");

    // R6: B writes A's box while busy
    cyc(0,0,0,0,'0, 1,1,0,1,16'h1234);
    check("R6", "aIntN", W'(aIntN), W'(1));
    cyc(1,0,0,0,'0, 0,0,0,0,'0);
    check("R6", "aRdata", aRdata, 16'h0000);

    // R9: A writes its own box; B writes its own box
    cyc(1,1,0,0,16'h7777, 1,1,1,0,16'h8888);
    check("R9", "aIntN", W'(aIntN), W'(1));
    check("R9", "bIntN", W'(bIntN), W'(1));
    cyc(1,0,0,0,'0, 1,0,1,0,'0);
    check("R9", "aRdata", aRdata, 16'h0000);
    check("R9", "bRdata", bRdata, 16'hA5C3);

    // R8: B sets A's interrupt while A reads its own box
    cyc(1,0,0,0,'0, 1,1,0,0,16'h5A5A);
    check("R8", "aIntN", W'(aIntN), W'(0));
    check("R8", "aRdata", aRdata, 16'h0000);
    cyc(1,0,0,0,'0, 0,0,0,0,'0);
    check("R8", "aRdata", aRdata, 16'h5A5A);
    check("R4", "aIntN", W'(aIntN), W'(1));

    // R11: full-width patterns
    cyc(0,0,0,0,'0, 1,1,0,0,16'hFFFF);
    cyc(1,0,0,0,'0, 0,0,0,0,'0);
    check("R11", "aRdata", aRdata, 16'hFFFF);
    cyc(1,1,1,0,16'h8001, 0,0,0,0,'0);
    cyc(0,0,0,0,'0, 1,0,1,0,'0);
    check("R11", "bRdata", bRdata, 16'h8001);
    checkAll("R11");

    // Random traffic checked against the model: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], r[2], (r[3] & r[4]), W'($urandom),
          r[5], r[6], r[7], (r[8] & r[9]), W'($urandom));
      checkAll("R2 R3 R4 R5 R6 R7 R8 R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule